// File: doc/BRIEF.md
# Formant Resonator Filter

This block is a fixed-point two-pole recursive filter that shapes a single formant of a parametric speech synthesizer. It computes each output from the current input sample and the two previous outputs: y[n] = A·x[n] + B·y[n-1] + C·y[n-2]. The result is a band-pass response centred on the formant frequency F, with a width set by the bandwidth BW.

A host works out the two feedback coefficients off-chip from F, BW and the sample period T:
- C = −exp(−2π·BW·T), which is always negative with magnitude below one.
- B = 2·exp(−π·BW·T)·cos(2π·F·T).

The host writes B and C as a pair with one strobe. The block then forms the feed-forward gain A = 1 − B − C itself, which fixes the gain at DC to exactly one.

Samples enter through a valid/ready handshake, one at a time. The output of each sample comes back as a one-cycle valid pulse two cycles later. A synchronous clear empties the two-sample history so that a new utterance starts from silence.

Top module: `formant_resonator`

## Requirements
- R1: After reset, `out_valid` and `out_data` are 0 and `in_ready` is 1. B and C reset to 0, so A is 1.0 and every output equals its input.
- R2: Samples are signed 16-bit values. B and C are signed 18-bit values with 15 fractional bits. A is held internally as 32768 − B − C. The output is (A·x + B·y1 + C·y2 + 16384) shifted arithmetically right by 15, where y1 and y2 are the two previous outputs.
- R3: A result above 32767 is output as 32767. A result below −32768 is output as −32768. The saturated value is also the value kept in the history.
- R4: If a sample is accepted in cycle t (`in_valid` and `in_ready` both high), `out_valid` is high in cycle t+2 only, with the result on `out_data`.
- R5: `in_ready` is low in the cycle after an accept and high again in the cycle after that.
- R6: A `coef_ld` pulse loads `coef_b` and `coef_c` together. The new pair applies to samples accepted in later cycles. A sample accepted in the same cycle as the load uses the previous pair.
- R7: `clr` sets both history values to zero. It takes priority over the history update of a sample that completes in the same cycle. That sample's output is still produced.
- R8: With a constant input, the output settles to within 3 LSB of the input value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous history clear |
| coef_ld | input | 1 | Load strobe for the coefficient pair |
| coef_b | input | 18 | Coefficient B, signed, 15 fractional bits |
| coef_c | input | 18 | Coefficient C, signed, 15 fractional bits |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 16 | Input sample, signed |
| out_valid | output | 1 | Output sample valid, one-cycle pulse |
| out_data | output | 16 | Output sample, signed |

## Verification
Pass-through samples after reset show that the default coefficients give A = 1 and that an empty history contributes nothing. An impulse driven through a narrow, high-Q pair brings out the feedback terms, because the ringing tail only matches the reference if B and C are weighted and ordered correctly. A stream of random samples exercises rounding on every sign combination. A long constant input through a wide-band pair checks the derived gain, since a wrong A appears as a DC offset. An overdriven gain separates saturation at both rails from wrap-around. Coefficient loads and clears timed against a sample in flight show whether the old or the new state was used.

// File: rtl/frm_pkg.sv
package frm_pkg;
    parameter int XW = 16;   // sample width
    parameter int CW = 18;   // coefficient width
    parameter int FB = 15;   // coefficient fractional bits

    localparam int AW   = CW + 2;        // derived gain needs two more bits
    localparam int ACCW = XW + AW + 4;   // accumulator with headroom

    typedef logic signed [XW-1:0]   smp_t;
    typedef logic signed [CW-1:0]   coef_t;
    typedef logic signed [AW-1:0]   gain_t;
    typedef logic signed [ACCW-1:0] acc_t;

    localparam gain_t A_ONE = gain_t'(1) <<< FB;
    localparam acc_t  S_HI  = acc_t'((2 ** (XW - 1)) - 1);
    localparam acc_t  S_LO  = -acc_t'(2 ** (XW - 1));

    // round half up, then clamp to the sample range
    function automatic acc_t round_q(acc_t s);
        return (s + (acc_t'(1) <<< (FB - 1))) >>> FB;
    endfunction

    function automatic smp_t clamp_s(acc_t r);
        if (r > S_HI) return smp_t'(S_HI);
        if (r < S_LO) return smp_t'(S_LO);
        return smp_t'(r);
    endfunction
endpackage

// File: rtl/frm_coef.sv
module frm_coef
    import frm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ld,
    input  coef_t b_in,
    input  coef_t c_in,
    output coef_t b_q,
    output coef_t c_q,
    output gain_t a_q
);
    typedef struct packed {
        coef_t b;
        coef_t c;
        gain_t a;
    } cst_t;

    cst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld) begin
            st_d.b = b_in;
            st_d.c = c_in;
            st_d.a = A_ONE - gain_t'(b_in) - gain_t'(c_in);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.b <= '0;
            st_q.c <= '0;
            st_q.a <= A_ONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign b_q = st_q.b;
    assign c_q = st_q.c;
    assign a_q = st_q.a;

    // the pair is captured together on a load
    assert_pair_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (b_q == $past(b_in)) && (c_q == $past(c_in)));

    // without a load the gain never moves
    assert_gain_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(a_q));
endmodule

// File: rtl/frm_mac.sv
module frm_mac
    import frm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  in_valid,
    input  smp_t  in_data,
    input  gain_t a_in,
    input  coef_t b_in,
    input  coef_t c_in,
    output logic  in_ready,
    output logic  out_valid,
    output smp_t  out_data
);
    typedef struct packed {
        logic busy;   // products registered, sum pending
        acc_t px;
        acc_t py1;
        acc_t py2;
        smp_t y1;
        smp_t y2;
        logic ov;
        smp_t od;
    } mst_t;

    mst_t st_d, st_q;
    logic take;
    acc_t sum_w;
    acc_t rnd_w;

    assign take  = in_valid && !st_q.busy;
    assign sum_w = st_q.px + st_q.py1 + st_q.py2;
    assign rnd_w = round_q(sum_w);

    always_comb begin
        st_d      = st_q;
        st_d.busy = take;
        st_d.ov   = st_q.busy;
        if (take) begin
            st_d.px  = acc_t'(in_data) * acc_t'(a_in);
            st_d.py1 = acc_t'(st_q.y1) * acc_t'(b_in);
            st_d.py2 = acc_t'(st_q.y2) * acc_t'(c_in);
        end
        if (st_q.busy) begin
            st_d.od = clamp_s(rnd_w);
            st_d.y2 = st_q.y1;
            st_d.y1 = clamp_s(rnd_w);
        end
        if (clr) begin
            st_d.y1 = '0;
            st_d.y2 = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready  = !st_q.busy;
    assign out_valid = st_q.ov;
    assign out_data  = st_q.od;

    assert_out_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_ready, 2));

    assert_out_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_ready_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    assert_hist_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.y1 == '0) && (st_q.y2 == '0));

    assert_clip_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && (rnd_w > S_HI)) |=> (out_data == smp_t'(S_HI)));

    assert_clip_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && (rnd_w < S_LO)) |=> (out_data == smp_t'(S_LO)));
endmodule

// File: rtl/formant_resonator.sv
module formant_resonator
    import frm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 coef_ld,
    input  logic signed [CW-1:0] coef_b,
    input  logic signed [CW-1:0] coef_c,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [XW-1:0] in_data,
    output logic                 out_valid,
    output logic signed [XW-1:0] out_data
);
    coef_t b_w, c_w;
    gain_t a_w;

    frm_coef i_coef (
        .clk  (clk),
        .rst_n(rst_n),
        .ld   (coef_ld),
        .b_in (coef_b),
        .c_in (coef_c),
        .b_q  (b_w),
        .c_q  (c_w),
        .a_q  (a_w)
    );

    frm_mac i_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .in_valid (in_valid),
        .in_data  (in_data),
        .a_in     (a_w),
        .b_in     (b_w),
        .c_in     (c_w),
        .in_ready (in_ready),
        .out_valid(out_valid),
        .out_data (out_data)
    );
endmodule

// File: tb/test_formant_resonator.sv
`timescale 1ns/1ps
module test_formant_resonator;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic coef_ld = 1'b0;
    logic signed [17:0] coef_b = '0;
    logic signed [17:0] coef_c = '0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic signed [15:0] in_data = '0;
    logic out_valid;
    logic signed [15:0] out_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // reference state
    longint mb = 0, mc = 0, ma = 32768, my1 = 0, my2 = 0;

    always #5 clk = ~clk;

    formant_resonator i_formant_resonator (
        .clk(clk), .rst_n(rst_n), .clr(clr), .coef_ld(coef_ld),
        .coef_b(coef_b), .coef_c(coef_c), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint model(input longint x);
        longint s, r;
        s = x * ma + my1 * mb + my2 * mc;
        r = (s + 16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        my2 = my1;
        my1 = r;
        return r;
    endfunction

    task automatic load(input longint b, input longint c);
        @(negedge clk);
        coef_ld = 1; coef_b = 18'(b); coef_c = 18'(c);
        @(negedge clk);
        coef_ld = 0;
        mb = b; mc = c; ma = 32768 - b - c;
    endtask

    task automatic clear();
        @(negedge clk); clr = 1;
        @(negedge clk); clr = 0;
        my1 = 0; my2 = 0;
    endtask

    // drive one sample, return its output and the handshake observations
    task automatic send(input longint x, output longint y, output bit v1, output bit r1, output bit v2);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1; in_data = 16'(x);
        @(negedge clk);
        in_valid = 0; v1 = out_valid; r1 = in_ready;
        @(negedge clk);
        v2 = out_valid; y = longint'(out_data);
    endtask

    task automatic t_reset();
        longint y; bit v1, r1, v2;
        chk("R1 out_valid", out_valid, 0);
        chk("R1 out_data", out_data, 0);
        chk("R1 in_ready", in_ready, 1);
        send(1234, y, v1, r1, v2);
        chk("R1 passthrough", y, 1234);
        send(-777, y, v1, r1, v2);
        chk("R1 passthrough neg", y, -777);
        my1 = -777; my2 = 1234;
    endtask

    task automatic t_timing();
        longint y; bit v1, r1, v2;
        send(55, y, v1, r1, v2);
        void'(model(55));
        chk("R4 no valid at t+1", v1, 0);
        chk("R4 valid at t+2", v2, 1);
        chk("R5 ready low after accept", r1, 0);
        chk("R5 ready back", in_ready, 1);
        @(negedge clk);
        chk("R4 single pulse", out_valid, 0);
    endtask

    task automatic t_impulse();
        longint y, e; bit v1, r1, v2; int bad = 0;
        load(60404, -30772);
        clear();
        send(16000, y, v1, r1, v2);
        e = model(16000);
        chk("R2 impulse first", y, 1531);
        chk("R2 impulse first model", y, e);
        for (int i = 0; i < 40; i++) begin
            send(0, y, v1, r1, v2);
            e = model(0);
            if (y != e) begin bad++; $display("FAIL R2 tail %0d: actual %0d expected %0d", i, y, e); end
        end
        chk("R2 impulse tail mismatches", bad, 0);
    endtask

    task automatic t_random();
        longint y, e, x; bit v1, r1, v2; int bad = 0;
        load(45528, -17489);
        clear();
        for (int i = 0; i < 300; i++) begin
            x = longint'($signed(16'($urandom)));
            send(x, y, v1, r1, v2);
            e = model(x);
            if (y != e) begin bad++; $display("FAIL R2 random %0d: actual %0d expected %0d", i, y, e); end
        end
        chk("R2 random mismatches", bad, 0);
    endtask

    task automatic t_dc();
        longint y, e, d; bit v1, r1, v2; int bad = 0;
        load(45528, -17489);
        clear();
        for (int i = 0; i < 80; i++) begin
            send(10000, y, v1, r1, v2);
            e = model(10000);
            if (y != e) bad++;
        end
        chk("R8 dc model mismatches", bad, 0);
        d = (y > 10000) ? y - 10000 : 10000 - y;
        chk("R8 dc settles within 3", (d <= 3), 1);
    endtask

    task automatic t_sat();
        longint y; bit v1, r1, v2;
        load(-65536, -32767);
        clear();
        send(20000, y, v1, r1, v2);
        chk("R3 clip high", y, 32767);
        clear();
        send(-20000, y, v1, r1, v2);
        chk("R3 clip low", y, -32768);
        // history holds the clipped value: next output uses y1 = -32768
        my1 = -32768; my2 = 0;
        send(0, y, v1, r1, v2);
        chk("R3 clipped history", y, model(0));
    endtask

    task automatic t_load_same_cycle();
        longint y, e;
        load(0, 0);
        clear();
        @(negedge clk);
        in_valid = 1; in_data = 16'(8000);
        coef_ld = 1; coef_b = 18'(60404); coef_c = 18'(-30772);
        @(negedge clk);
        in_valid = 0; coef_ld = 0;
        @(negedge clk);
        y = longint'(out_data);
        e = model(8000);
        chk("R6 same-cycle load uses old pair", y, e);
        mb = 60404; mc = -30772; ma = 32768 - mb - mc;
        begin
            bit v1, r1, v2;
            send(0, y, v1, r1, v2);
            chk("R6 new pair applies next", y, model(0));
        end
    endtask

    task automatic t_clear_priority();
        longint y; bit v1, r1, v2;
        load(60404, -30772);
        clear();
        send(12000, y, v1, r1, v2);
        void'(model(12000));
        @(negedge clk);
        in_valid = 1; in_data = 16'(9000);
        @(negedge clk);
        in_valid = 0; clr = 1;
        @(negedge clk);
        clr = 0;
        y = longint'(out_data);
        chk("R7 output still produced", y, model(9000));
        my1 = 0; my2 = 0;
        send(7000, y, v1, r1, v2);
        chk("R7 history cleared", y, (7000 * 3136 + 16384) >>> 15);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_timing();
        t_impulse();
        t_random();
        t_dc();
        t_sat();
        t_load_same_cycle();
        t_clear_priority();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule